// File: doc/BRIEF.md
# Integer Execute Stage with Three-Way Compare

This block is the combinational execute stage of a small 32-bit load/store core. Each cycle the surrounding pipeline presents an operation code, two register source values, a constant and a selector that chooses between the constant and the second register, together with the current status word. In the same cycle the block returns the result to write back, a write enable and the status word for the next cycle.

Arithmetic and logic operations never touch the status word. Compare is the only operation that changes it. Compare also never writes a register. It discards every previous status bit and sets exactly one of three flags, based on a signed three-way ordering of its operands. Branch logic outside the block then tests one flag at a time.

Register storage, decode, memory access and branching are handled elsewhere.

Top module: `exec_alu`

## Requirements
- R1: Operation code 0 (add) outputs the sum of `src_a` and a second operand, modulo 2^32, with `wr_en` high. The second operand is `imm` when `use_imm` is 1 and `src_b` when it is 0.
- R2: Operation code 1 (subtract) outputs `src_a - src_b` modulo 2^32 with `wr_en` high. `use_imm` has no effect.
- R3: Operation codes 2, 3 and 4 output the bitwise AND, OR and exclusive-OR of `src_a` and `src_b`, with `wr_en` high. `use_imm` has no effect.
- R4: Operation code 5 (bit-clear) outputs `src_a & ~src_b` with `wr_en` high.
- R5: Operation code 6 (move) outputs `imm` when `use_imm` is 1 and `src_b` when it is 0, with `wr_en` high.
- R6: Operation code 7 (compare) holds `wr_en` low. Its second operand is `imm` when `use_imm` is 1 and `src_b` when it is 0.
- R7: For compare, both operands are treated as signed. `status_out` is all zeros except for exactly one flag:
  - bit 31 (N) is set when the first operand is less than the second;
  - bit 30 (Z) is set when the two operands are equal;
  - bit 29 (C) is set when the first operand is greater.
- R8: For operation codes 0 to 6, `status_out` equals `status_in`.
- R9: Operation codes 8 to 15 hold `wr_en` low and pass `status_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 32 | Constant operand |
| use_imm | input | 1 | Selects `imm` over `src_b` for add, move and compare |
| status_in | input | 32 | Current status word |
| wr_data | output | 32 | Destination write value |
| wr_en | output | 1 | Destination write enable |
| status_out | output | 32 | Next status word |

## Verification
The hardest cases are the compares where signed and unsigned ordering disagree. These are operand pairs that straddle the sign boundary, such as 0x80000000 against 0x7FFFFFFF. A plain subtract-and-borrow scheme would set C for such a pair instead of N.

The stimulus applies those pairs in both orders and through both the register and the constant path. It first loads `status_in` with all ones so that any bit compare fails to clear becomes visible.

// File: rtl/exec_alu.sv
module exec_alu #(
  parameter int W     = 32,
  parameter int OPW   = 4,
  parameter int N_POS = 31,
  parameter int Z_POS = 30,
  parameter int C_POS = 29
) (
  input  logic [OPW-1:0] op_sel,
  input  logic [W-1:0]   src_a,
  input  logic [W-1:0]   src_b,
  input  logic [W-1:0]   imm,
  input  logic           use_imm,
  input  logic [W-1:0]   status_in,
  output logic [W-1:0]   wr_data,
  output logic           wr_en,
  output logic [W-1:0]   status_out
);
  localparam logic [OPW-1:0] OP_ADD = 0, OP_SUB = 1, OP_AND = 2, OP_ORR = 3,
                             OP_EOR = 4, OP_BIC = 5, OP_MOV = 6, OP_CMP = 7;

  logic [W-1:0] opnd2;
  logic         is_lt, is_eq;

  assign opnd2 = use_imm ? imm : src_b;
  assign is_lt = $signed(src_a) < $signed(opnd2);
  assign is_eq = src_a == opnd2;

  always_comb begin
    wr_en   = 1'b1;
    wr_data = '0;
    unique case (op_sel)
      OP_ADD:  wr_data = src_a + opnd2;
      OP_SUB:  wr_data = src_a - src_b;
      OP_AND:  wr_data = src_a & src_b;
      OP_ORR:  wr_data = src_a | src_b;
      OP_EOR:  wr_data = src_a ^ src_b;
      OP_BIC:  wr_data = src_a & ~src_b;
      OP_MOV:  wr_data = opnd2;
      default: wr_en   = 1'b0;
    endcase
  end

  always_comb begin
    status_out = status_in;
    if (op_sel == OP_CMP) begin
      status_out = '0;
      if (is_lt)      status_out[N_POS] = 1'b1;
      else if (is_eq) status_out[Z_POS] = 1'b1;
      else            status_out[C_POS] = 1'b1;
    end
  end

  always_comb begin
    if (op_sel == OP_CMP) begin
      AST_CMP_NO_WRITE: assert (!wr_en); // R6
      AST_CMP_ONE_FLAG: assert ($countones(status_out) == 1 &&
        (status_out[N_POS] | status_out[Z_POS] | status_out[C_POS])); // R7
    end else begin
      AST_STATUS_HELD: assert (status_out == status_in); // R8
    end
    if (wr_en) begin
      AST_WRITE_CODES: assert (op_sel <= OP_MOV); // R9
    end
  end
endmodule

// File: tb/exec_alu_tb.sv
module exec_alu_tb;
  logic        clk = 0;
  logic [3:0]  op_sel = 0;
  logic [31:0] src_a = 0, src_b = 0, imm = 0, status_in = 0;
  logic        use_imm = 0;
  logic [31:0] wr_data, status_out;
  logic        wr_en;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [31:0] FN = 32'h8000_0000, FZ = 32'h4000_0000, FC = 32'h2000_0000;

  always #4 clk = ~clk;

  exec_alu u_dut (.op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
    .use_imm(use_imm), .status_in(status_in), .wr_data(wr_data), .wr_en(wr_en),
    .status_out(status_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] o, logic [31:0] a, logic [31:0] b,
                       logic [31:0] k, logic u, logic [31:0] s);
    @(negedge clk);
    op_sel = o; src_a = a; src_b = b; imm = k; use_imm = u; status_in = s;
    #1;
  endtask

  task automatic t_reset_state;
    apply(4'd0, 0, 0, 0, 0, 0);
    chk("R1 idle data", wr_data, 0);
    chk("R1 idle en", {31'b0, wr_en}, 1);
    chk("R8 idle status", status_out, 0);
  endtask

  task automatic t_add;
    apply(4'd0, 32'hFFFF_FFFF, 32'd2, 32'd100, 0, 32'h1234_5678);
    chk("R1 add reg wrap", wr_data, 32'd1);
    chk("R8 add status", status_out, 32'h1234_5678);
    apply(4'd0, 32'd5, 32'd2, 32'd100, 1, 32'hFFFF_FFFF);
    chk("R1 add imm", wr_data, 32'd105);
    chk("R8 add status ones", status_out, 32'hFFFF_FFFF);
  endtask

  task automatic t_sub;
    apply(4'd1, 32'd3, 32'd5, 32'd1, 1, 0);
    chk("R2 sub wrap imm ignored", wr_data, 32'hFFFF_FFFE);
    chk("R2 sub en", {31'b0, wr_en}, 1);
  endtask

  task automatic t_logic;
    apply(4'd2, 32'hF0F0_1234, 32'hFF00_FF00, 32'h0, 1, 0);
    chk("R3 and", wr_data, 32'hF000_1200);
    apply(4'd3, 32'hF0F0_1234, 32'hFF00_FF00, 32'h0, 1, 0);
    chk("R3 or", wr_data, 32'hFFF0_FF34);
    apply(4'd4, 32'hF0F0_1234, 32'hFF00_FF00, 32'h0, 1, 0);
    chk("R3 xor", wr_data, 32'h0FF0_ED34);
    apply(4'd5, 32'hF0F0_1234, 32'hFF00_FF00, 32'hFFFF_FFFF, 1, FN);
    chk("R4 bic", wr_data, 32'h00F0_0034);
    chk("R8 bic status", status_out, FN);
  endtask

  task automatic t_move;
    apply(4'd6, 32'h1, 32'hAAAA_5555, 32'hDEAD_BEEF, 1, 0);
    chk("R5 mov imm", wr_data, 32'hDEAD_BEEF);
    apply(4'd6, 32'h1, 32'hAAAA_5555, 32'hDEAD_BEEF, 0, 0);
    chk("R5 mov reg", wr_data, 32'hAAAA_5555);
  endtask

  task automatic t_compare;
    apply(4'd7, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 32'hFFFF_FFFF);
    chk("R7 min<max N", status_out, FN);
    chk("R6 cmp no write", {31'b0, wr_en}, 0);
    apply(4'd7, 32'h7FFF_FFFF, 32'h0, 32'h8000_0000, 1, 32'hFFFF_FFFF);
    chk("R7 max>min C imm", status_out, FC);
    apply(4'd7, 32'hFFFF_FFFF, 32'd1, 0, 0, 32'hFFFF_FFFF);
    chk("R7 -1<1 N", status_out, FN);
    apply(4'd7, 32'd42, 32'd7, 32'd42, 1, 32'hFFFF_FFFF);
    chk("R6 imm path equal Z", status_out, FZ);
    apply(4'd7, 32'd42, 32'd42, 32'd7, 0, 32'h0);
    chk("R7 reg equal Z", status_out, FZ);
    apply(4'd7, 32'd9, 32'hFFFF_FFF0, 0, 0, 32'h0);
    chk("R7 9>-16 C", status_out, FC);
  endtask

  task automatic t_unused;
    for (int c = 8; c < 16; c++) begin
      apply(c[3:0], 32'h5, 32'h6, 32'h7, 1, 32'hA5A5_0F0F);
      chk("R9 unused en", {31'b0, wr_en}, 0);
      chk("R9 unused status", status_out, 32'hA5A5_0F0F);
    end
  endtask

  initial begin
    t_reset_state();
    t_add();
    t_sub();
    t_logic();
    t_move();
    t_compare();
    t_unused();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule